// File: doc/BRIEF.md
# Pad Interrupt Router

This block sits between a wide bank of general-purpose pads and a parent interrupt controller that only understands active-high signals. It has eight interrupt channels. Each channel picks any one pad through an 8-bit selector, brings it into the clock domain with a two-flop synchroniser, can pass it through a programmable glitch filter, and can invert it. It then presents it to the parent either as a level or as a one-cycle pulse. Inversion is how active-low levels and falling edges reach a parent that accepts only high levels and rising edges. Sensing both edges is not offered.

Software configures the router through four 32-bit words on a small word-addressed bus. Writes take effect on the clock edge where `bus_we` is high, and reads are combinational. The number of pads actually wired is a parameter. A selector value that points past the last wired pad reads a constant low. An asynchronous active-low reset is released to the logic through a two-stage synchroniser, so the first usable cycle comes two clocks after `rst_n` rises.

Top module: `pad_irq_router`

## Requirements
- R1: After reset all four configuration words read 0 and every `irq_out` bit is low. This is level mode, no inversion, pad 0 and no filter.
- R2: Word 0 keeps the edge-enable bits in [7:0] and the invert bits in [23:16]. Its bits [15:8] and [31:24] always read 0. Word 3 keeps eight 4-bit filter fields, with channel x in bits [4x+3:4x]. Every word reads back what was last written to its used bits.
- R3: Channels 0 to 3 take their pad selectors from word 1 and channels 4 to 7 from word 2. Channel x uses bits [8(x mod 4)+7 : 8(x mod 4)]. Each channel follows only the pad it selects.
- R4: In level mode with no inversion and a filter value of 0, `irq_out[x]` equals the selected pad. The output changes on the third rising clock edge after the pad changes.
- R5: With the invert bit set in level mode, `irq_out[x]` is the complement of the selected pad.
- R6: With the edge bit set and no inversion, a low-to-high pad transition gives `irq_out[x]` high for exactly one cycle, on the third edge after the change. A high-to-low transition gives nothing.
- R7: With both the edge bit and the invert bit set, only a high-to-low pad transition gives the one-cycle pulse, with the same latency as R6.
- R8: A nonzero filter value N accepts a pad change only after the change has been held for 4N cycles. The output then moves on edge 3+4N after the change. A pulse shorter than 4N cycles has no effect on the output.
- R9: A selector value at or above `PAD_COUNT` reads a constant low input, whatever the pads do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | PAD_COUNT | Pad inputs, asynchronous to `clk` |
| bus_we | input | 1 | Write strobe for the configuration bus |
| bus_addr | input | 2 | Word index: 0 sense/invert, 1 selectors ch0-3, 2 selectors ch4-7, 3 filters |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_addr` |
| irq_out | output | 8 | Active-high interrupt lines to the parent controller |

## Verification
The bench builds the router with `PAD_COUNT` set to 12 rather than the default of 134. With only twelve pads wired, selector values such as 12 and 200 fall outside the wired range, so the constant-low path can be reached from ordinary register writes. A filter value of 2 keeps the 8-cycle acceptance window short. That lets both the rejected glitch and the exact acceptance edge be observed at cycle precision.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NUM_CH      = 8;
  localparam int HALF_CH     = NUM_CH / 2;
  localparam int SEL_W       = 8;
  localparam int PAD_SPACE   = 1 << SEL_W;
  localparam int FILT_W      = 4;
  localparam int FILT_SHIFT  = 2;               // filter step of 4 cycles
  localparam int FCNT_W      = FILT_W + FILT_SHIFT;
  localparam int WORD_W      = 32;

  typedef enum logic [1:0] {
    W_SENSE  = 2'd0,
    W_SEL_LO = 2'd1,
    W_SEL_HI = 2'd2,
    W_FILT   = 2'd3
  } word_idx_e;

  typedef logic [NUM_CH-1:0][SEL_W-1:0]  sel_vec_t;
  typedef logic [NUM_CH-1:0][FILT_W-1:0] filt_vec_t;
endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [NUM_CH-1:0] edge_en,
  output logic [NUM_CH-1:0] inv_en,
  output sel_vec_t          pad_sel,
  output filt_vec_t         filt_sel
);

  logic [NUM_CH-1:0] edge_q, edge_d, inv_q, inv_d;
  sel_vec_t          sel_q, sel_d;
  filt_vec_t         filt_q, filt_d;
  word_idx_e         widx;

  assign widx = word_idx_e'(addr);

  // next-state
  always_comb begin
    edge_d = edge_q;
    inv_d  = inv_q;
    sel_d  = sel_q;
    filt_d = filt_q;
    if (wr_en) begin
      unique case (widx)
        W_SENSE: begin
          edge_d = wdata[NUM_CH-1:0];
          inv_d  = wdata[16 +: NUM_CH];
        end
        W_SEL_LO: sel_d[HALF_CH-1:0]      = wdata;
        W_SEL_HI: sel_d[NUM_CH-1:HALF_CH] = wdata;
        W_FILT:   filt_d                  = wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      inv_q  <= '0;
      sel_q  <= '0;
      filt_q <= '0;
    end else begin
      edge_q <= edge_d;
      inv_q  <= inv_d;
      sel_q  <= sel_d;
      filt_q <= filt_d;
    end
  end

  // read mux, unused bits zero
  always_comb begin
    unique case (widx)
      W_SENSE:  rdata = {8'd0, inv_q, 8'd0, edge_q};
      W_SEL_LO: rdata = sel_q[HALF_CH-1:0];
      W_SEL_HI: rdata = sel_q[NUM_CH-1:HALF_CH];
      W_FILT:   rdata = filt_q;
      default:  rdata = '0;
    endcase
  end

  assign edge_en  = edge_q;
  assign inv_en   = inv_q;
  assign pad_sel  = sel_q;
  assign filt_sel = filt_q;

endmodule

// File: rtl/pirq_filter.sv
module pirq_filter
  import pirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [FILT_W-1:0] nsel,
  output logic              dout
);

  logic              acc_q, acc_d;
  logic [FCNT_W-1:0] cnt_q, cnt_d;
  logic [FCNT_W-1:0] span;
  logic              bypass;

  assign span   = {nsel, {FILT_SHIFT{1'b0}}};
  assign bypass = (nsel == '0);

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (bypass) begin
      acc_d = din;
      cnt_d = '0;
    end else if (din == acc_q) begin
      cnt_d = '0;
    end else if (cnt_q >= span - FCNT_W'(1)) begin
      acc_d = din;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + FCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout = bypass ? din : acc_q;

endmodule

// File: rtl/pirq_channel.sv
module pirq_channel
  import pirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_bit,
  input  logic              edge_mode,
  input  logic              invert,
  input  logic [FILT_W-1:0] filt_n,
  output logic              irq
);

  logic [1:0] sync_q;
  logic       filt_out;
  logic       lvl;
  logic       lvl_prev_q;
  logic       irq_q, irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], pad_bit};
  end

  pirq_filter u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sync_q[1]),
    .nsel (filt_n),
    .dout (filt_out)
  );

  assign lvl = filt_out ^ invert;

  always_comb begin
    if (edge_mode) irq_d = lvl & ~lvl_prev_q;
    else           irq_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      lvl_prev_q <= lvl;
      irq_q      <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
  import pirq_pkg::*;
#(
  parameter int PAD_COUNT = 134
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PAD_COUNT-1:0] pad_in,
  input  logic                 bus_we,
  input  logic [1:0]           bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_CH-1:0]    irq_out
);

  logic [1:0]           rst_pipe_q;
  logic                 rst_core_n;
  logic [NUM_CH-1:0]    edge_en;
  logic [NUM_CH-1:0]    inv_en;
  sel_vec_t             pad_sel;
  filt_vec_t            filt_sel;
  logic [PAD_SPACE-1:0] pad_ext;
  logic [NUM_CH-1:0]    chan_pad;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  pirq_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .edge_en (edge_en),
    .inv_en  (inv_en),
    .pad_sel (pad_sel),
    .filt_sel(filt_sel)
  );

  // unwired selector codes land on zero bits
  always_comb begin
    pad_ext = '0;
    pad_ext[PAD_COUNT-1:0] = pad_in;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign chan_pad[c] = pad_ext[pad_sel[c]];

    pirq_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .pad_bit  (chan_pad[c]),
      .edge_mode(edge_en[c]),
      .invert   (inv_en[c]),
      .filt_n   (filt_sel[c]),
      .irq      (irq_out[c])
    );
  end

endmodule

// File: rtl/pirq_checker.sv
module pirq_checker
  import pirq_pkg::*;
#(
  parameter int PAD_COUNT = 134
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] irq_out,
  input logic [NUM_CH-1:0] edge_en,
  input sel_vec_t          pad_sel,
  input filt_vec_t         filt_sel,
  input logic [NUM_CH-1:0] chan_pad
);

  p_clean_reset_r1: assert property (@(posedge clk)
    $rose(rst_core_n) |-> (irq_out == '0 && edge_en == '0 && filt_sel == '0));

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr == 2'd0) |-> (bus_rdata[15:8] == 8'd0 && bus_rdata[31:24] == 8'd0));

  p_filt_write_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == 2'd3) |=> (filt_sel == $past(bus_wdata)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_oob_low_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
      ({24'd0, pad_sel[c]} >= 32'(PAD_COUNT)) |-> !chan_pad[c]);

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
      (edge_en[c] && $past(edge_en[c]) && $past(irq_out[c])) |-> !irq_out[c]);
  end

endmodule

bind pad_irq_router pirq_checker #(.PAD_COUNT(PAD_COUNT)) u_pirq_chk (
  .clk       (clk),
  .rst_core_n(rst_core_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .edge_en   (edge_en),
  .pad_sel   (pad_sel),
  .filt_sel  (filt_sel),
  .chan_pad  (chan_pad)
);

// File: tb/tb_pad_irq_router.sv
module tb_pad_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NPADS      = 12;

  logic              clk;
  logic              rst_n;
  logic [NPADS-1:0]  pad_in;
  logic              bus_we;
  logic [1:0]        bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [7:0]        irq_out;

  int checks = 0;
  int errors = 0;

  pad_irq_router #(.PAD_COUNT(NPADS)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance n rising edges, land on the following falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic clear_cfg();
    for (int w = 0; w < 4; w++) wr(w[1:0], 32'd0);
    pad_in = '0;
    step(6);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      rd(w[1:0], d);
      chk("R1 reset word", d, 32'd0);
    end
    chk("R1 reset irq", {24'd0, irq_out}, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 sense word unused bits", d, 32'h00FF_00FF);
    wr(2'd1, 32'hA53C_1207);
    rd(2'd1, d); chk("R2 sel lo readback", d, 32'hA53C_1207);
    wr(2'd2, 32'h0B6E_D481);
    rd(2'd2, d); chk("R2 sel hi readback", d, 32'h0B6E_D481);
    wr(2'd3, 32'h9ABC_DEF1);
    rd(2'd3, d); chk("R2 filt readback", d, 32'h9ABC_DEF1);
    clear_cfg();
  endtask

  task automatic t_level();
    wr(2'd1, 32'h0000_0003);          // ch0 -> pad 3
    step(4);
    pad_in[3] = 1'b1;
    step(2); chk("R4 level before third edge", {31'd0, irq_out[0]}, 32'd0);
    step(1); chk("R4 level on third edge", {31'd0, irq_out[0]}, 32'd1);
    pad_in[3] = 1'b0;
    step(3); chk("R4 level falls", {31'd0, irq_out[0]}, 32'd0);
  endtask

  task automatic t_invert();
    wr(2'd0, 32'h0001_0000);          // ch0 invert
    step(1); chk("R5 inverted low pad", {31'd0, irq_out[0]}, 32'd1);
    pad_in[3] = 1'b1;
    step(3); chk("R5 inverted high pad", {31'd0, irq_out[0]}, 32'd0);
    clear_cfg();
  endtask

  task automatic t_edge_rise();
    int hits;
    wr(2'd1, 32'h0000_0500);          // ch1 -> pad 5
    wr(2'd0, 32'h0000_0002);          // ch1 edge
    step(4);
    pad_in[5] = 1'b1;
    step(2); chk("R6 no pulse yet", {31'd0, irq_out[1]}, 32'd0);
    step(1); chk("R6 pulse on third edge", {31'd0, irq_out[1]}, 32'd1);
    step(1); chk("R6 pulse one cycle", {31'd0, irq_out[1]}, 32'd0);
    pad_in[5] = 1'b0;
    hits = 0;
    for (int i = 0; i < 6; i++) begin step(1); hits += irq_out[1]; end
    chk("R6 falling ignored", 32'(hits), 32'd0);
    clear_cfg();
  endtask

  task automatic t_edge_fall();
    int hits;
    wr(2'd2, 32'h0000_0700);          // ch5 -> pad 7
    wr(2'd0, 32'h0020_0020);          // ch5 edge + invert
    step(4);
    pad_in[7] = 1'b1;
    hits = 0;
    for (int i = 0; i < 6; i++) begin step(1); hits += irq_out[5]; end
    chk("R7 rising ignored", 32'(hits), 32'd0);
    pad_in[7] = 1'b0;
    step(2); chk("R7 no pulse yet", {31'd0, irq_out[5]}, 32'd0);
    step(1); chk("R7 pulse on fall", {31'd0, irq_out[5]}, 32'd1);
    step(1); chk("R7 pulse one cycle", {31'd0, irq_out[5]}, 32'd0);
    clear_cfg();
  endtask

  task automatic t_filter();
    int hits;
    wr(2'd1, 32'h0009_0000);          // ch2 -> pad 9
    wr(2'd3, 32'h0000_0200);          // ch2 filter 2 -> 8 cycles
    step(4);
    pad_in[9] = 1'b1;
    step(5);
    pad_in[9] = 1'b0;
    hits = 0;
    for (int i = 0; i < 15; i++) begin step(1); hits += irq_out[2]; end
    chk("R8 short glitch rejected", 32'(hits), 32'd0);
    pad_in[9] = 1'b1;
    step(10); chk("R8 not yet accepted", {31'd0, irq_out[2]}, 32'd0);
    step(1);  chk("R8 accepted on edge 11", {31'd0, irq_out[2]}, 32'd1);
    clear_cfg();
  endtask

  task automatic t_oob();
    wr(2'd1, 32'h0C00_0000);          // ch3 -> 12, outside wired range
    wr(2'd2, 32'h0000_00C8);          // ch4 -> 200
    pad_in = '1;
    step(6);
    chk("R9 sel 12 low", {31'd0, irq_out[3]}, 32'd0);
    chk("R9 sel 200 low", {31'd0, irq_out[4]}, 32'd0);
    clear_cfg();
  endtask

  task automatic t_fields();
    wr(2'd2, 32'h000A_000B);          // ch6 -> pad 10, ch4 -> pad 11
    pad_in = '0;
    pad_in[10] = 1'b1;
    step(4);
    chk("R3 ch6 follows pad 10", {31'd0, irq_out[6]}, 32'd1);
    chk("R3 ch4 idle", {31'd0, irq_out[4]}, 32'd0);
    chk("R3 others idle", {24'd0, irq_out & 8'hBF}, 32'd0);
    pad_in[10] = 1'b0; pad_in[11] = 1'b1;
    step(4);
    chk("R3 ch4 follows pad 11", {24'd0, irq_out}, 32'h0000_0010);
    clear_cfg();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pad_in = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_regs();
    t_level();
    t_invert();
    t_edge_rise();
    t_edge_fall();
    t_filter();
    t_oob();
    t_fields();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule